// File: doc/BRIEF.md
# Root hub port status and control register

This block holds the status and control state of one downstream port of a USB host controller root hub. Host software reads a word that shows the port's live condition and writes a word in which each set bit is a command. A bit position means one thing on read and another on write. For example, bit 1 reads as "port enabled" and, when written with 1, asks the hardware to enable the port. Writing 0 to any position does nothing.

The port logic feeds the register with its signals: device presence, port power, overcurrent, babble or bus error, reset completion, resume-interval completion and the controller entering its resume state. From these the register keeps the enable, suspend and resume-request controls and four sticky change flags. Software clears a change flag by writing 1 to it.

A command that needs an attached device but targets an empty port does not act. Instead it raises the connect-change flag, so software learns that the port became empty under it.

Top module: `rh_port_reg`

## Requirements
- R1: After reset, enable, suspend, resume request and all four change flags are 0.
- R2: Read bit 0 shows the device-present input directly. Read bit 3 shows the overcurrent input directly when per-port overcurrent reporting is configured, and reads 0 otherwise. Read bit 1 is enable, bit 2 is suspend, bit 4 is resume request, and bits 16 to 19 are the change flags.
- R3: Writing 1 to bit 1 enables a port that has a device present. On an empty port the write leaves enable at 0 and sets the connect-change flag (bit 16). Enable is never 1 in the cycle after the device-present input was low.
- R4: Writing 1 to bit 0 clears enable and does not set the enable-change flag.
- R5: Overcurrent, loss of port power, babble or absence of a device clears enable. If enable was 1, the same event sets the enable-change flag (bit 17).
- R6: Enable is forced on when a port reset completes, and also when a resume completes, provided a device is present and no disable condition holds.
- R7: Writing 1 to bit 2 suspends a port that has a device present. On an empty port the write leaves suspend at 0 and sets the connect-change flag.
- R8: Writing 1 to bit 3 raises the resume request, but only on a suspended port. Suspend stays at 1 until the resume interval completes. Completion then clears both suspend and the request and sets the suspend-change flag (bit 18).
- R9: Suspend and the resume request are cleared by port reset completion, by the controller entering its resume state, and by removal of the device.
- R10: Any change of the device-present input, rising or falling, sets the connect-change flag.
- R11: With per-port overcurrent reporting, any change of the overcurrent input sets the overcurrent-change flag (bit 19).
- R12: Writing 1 to bit 16+i clears change flag i. A hardware event that sets that flag in the same cycle wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write word; each set bit is a command |
| rd_data | output | DATA_W | Live read word |
| dev_connected | input | 1 | A device is attached to the port |
| port_powered | input | 1 | Port power is on |
| overcurrent | input | 1 | Overcurrent detected on the port |
| babble | input | 1 | Babble or bus error detected |
| reset_done | input | 1 | One-cycle pulse at the end of a port reset |
| resume_done | input | 1 | One-cycle pulse at the end of the resume interval |
| hc_resume | input | 1 | Controller enters its resume state |
| port_enable | output | 1 | Port enabled |
| port_suspend | output | 1 | Port suspended or resuming |
| resume_req | output | 1 | Resume signalling requested |
| change_flags | output | 4 | Connect, enable, suspend and overcurrent change flags |

## Verification
All state is a single level of registers, so a wrong next-state decision appears on the outputs and in the read word in the first cycle after the event that caused it. A missed or spurious change flag is sticky and stays visible until software clears it. A wrong enable or suspend value persists until the next command or hardware event. Comparing every output on every clock therefore pins each mismatch to the exact cycle of the faulty decision.

// File: rtl/rh_port_pkg.sv
`timescale 1ns/1ps
package rh_port_pkg;
  // read/write bit positions; software decodes these
  localparam int POS_CONN = 0;  // read: present   write: clear enable
  localparam int POS_EN   = 1;  // read: enabled   write: set enable
  localparam int POS_SUSP = 2;  // read: suspended write: set suspend
  localparam int POS_OC   = 3;  // read: overcur.  write: start resume
  localparam int POS_RSM  = 4;  // read: resume request
  localparam int CHG_BASE = 16;
  localparam int NCHG     = 4;

  // change flag indices
  localparam int CF_CONN = 0;
  localparam int CF_EN   = 1;
  localparam int CF_SUSP = 2;
  localparam int CF_OC   = 3;

  // any condition that forbids an enabled port
  function automatic logic port_blocked(input logic present, input logic powered,
                                        input logic ovc, input logic bab);
    return !present || !powered || ovc || bab;
  endfunction

  // sticky flag with write-one-clear, set dominant
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set || (cur && !clr);
  endfunction
endpackage

// File: rtl/rh_enable_ctl.sv
`timescale 1ns/1ps
module rh_enable_ctl
  import rh_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic powered,
  input  logic ovc,
  input  logic bab,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic reset_done,
  input  logic resume_fin,
  output logic enable_q,
  output logic en_dropped,
  output logic en_refused
);
  logic blocked;
  logic enable_n;

  assign blocked    = port_blocked(present, powered, ovc, bab);
  assign en_dropped = enable_q && blocked;
  assign en_refused = set_cmd && !present;

  always_comb begin
    enable_n = enable_q;
    if (blocked)                                   enable_n = 1'b0;
    else if (clr_cmd)                              enable_n = 1'b0;
    else if (set_cmd || reset_done || resume_fin)  enable_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable_q <= 1'b0;
    else        enable_q <= enable_n;
  end

  // R3
  en_needs_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> !enable_q);
  // R5
  en_hw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc || bab || !powered) |=> !enable_q);
  // R4
  en_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !enable_q);
  // R6
  en_reset_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && present && powered && !ovc && !bab && !clr_cmd) |=> enable_q);
endmodule

// File: rtl/rh_suspend_ctl.sv
`timescale 1ns/1ps
module rh_suspend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic set_cmd,
  input  logic resume_cmd,
  input  logic reset_done,
  input  logic resume_done,
  input  logic hc_resume,
  output logic suspend_q,
  output logic resume_q,
  output logic resume_fin,
  output logic susp_refused
);
  logic suspend_n;
  logic resume_n;
  logic kill;

  assign resume_fin   = suspend_q && resume_q && resume_done;
  assign kill         = !present || reset_done || hc_resume || resume_fin;
  assign susp_refused = set_cmd && !present;

  always_comb begin
    suspend_n = suspend_q;
    if (kill)         suspend_n = 1'b0;
    else if (set_cmd) suspend_n = 1'b1;
    // a resume command only counts on a port already suspended
    resume_n = suspend_n && (resume_q || (resume_cmd && suspend_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suspend_q <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      suspend_q <= suspend_n;
      resume_q  <= resume_n;
    end
  end

  // R8
  rsm_only_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> suspend_q);
  // R8
  rsm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend_q && !resume_q) |=> !resume_q);
  // R9
  susp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done || hc_resume || !present) |=> !suspend_q);
  // R7
  susp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && present && !reset_done && !hc_resume && !resume_fin) |=> suspend_q);
endmodule

// File: rtl/rh_change_flags.sv
`timescale 1ns/1ps
module rh_change_flags
  import rh_port_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= sticky_next(flags_q[i], set_ev[i], clr_cmd[i]);
    end

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags_q[i]);
    // R12
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd[i] && !set_ev[i]) |=> !flags_q[i]);
  end
endmodule

// File: rtl/rh_port_reg.sv
`timescale 1ns/1ps
module rh_port_reg
  import rh_port_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter bit OC_PER_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dev_connected,
  input  logic              port_powered,
  input  logic              overcurrent,
  input  logic              babble,
  input  logic              reset_done,
  input  logic              resume_done,
  input  logic              hc_resume,
  output logic              port_enable,
  output logic              port_suspend,
  output logic              resume_req,
  output logic [NCHG-1:0]   change_flags
);
  localparam int CHG_TOP = CHG_BASE + NCHG - 1;

  // decoded write commands
  logic cmd_clr_en, cmd_set_en, cmd_set_susp, cmd_resume;
  logic [NCHG-1:0] cmd_chg_clr;
  logic unused_wr_bits;

  assign cmd_clr_en   = wr_en && wr_data[POS_CONN];
  assign cmd_set_en   = wr_en && wr_data[POS_EN];
  assign cmd_set_susp = wr_en && wr_data[POS_SUSP];
  assign cmd_resume   = wr_en && wr_data[POS_OC];
  assign cmd_chg_clr  = wr_en ? wr_data[CHG_TOP:CHG_BASE] : '0;
  assign unused_wr_bits = ^wr_data;

  // input history for edge events
  logic conn_q, oc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      conn_q <= dev_connected;
      oc_q   <= overcurrent;
    end
  end

  // named internal events
  logic conn_edge, oc_edge, oc_seen;
  logic en_dropped, en_refused, susp_refused, resume_fin;
  assign conn_edge = dev_connected ^ conn_q;
  assign oc_seen   = OC_PER_PORT ? overcurrent : 1'b0;
  assign oc_edge   = OC_PER_PORT ? (overcurrent ^ oc_q) : 1'b0;

  rh_enable_ctl u_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .present    (dev_connected),
    .powered    (port_powered),
    .ovc        (overcurrent),
    .bab        (babble),
    .set_cmd    (cmd_set_en),
    .clr_cmd    (cmd_clr_en),
    .reset_done (reset_done),
    .resume_fin (resume_fin),
    .enable_q   (port_enable),
    .en_dropped (en_dropped),
    .en_refused (en_refused)
  );

  rh_suspend_ctl u_suspend (
    .clk          (clk),
    .rst_n        (rst_n),
    .present      (dev_connected),
    .set_cmd      (cmd_set_susp),
    .resume_cmd   (cmd_resume),
    .reset_done   (reset_done),
    .resume_done  (resume_done),
    .hc_resume    (hc_resume),
    .suspend_q    (port_suspend),
    .resume_q     (resume_req),
    .resume_fin   (resume_fin),
    .susp_refused (susp_refused)
  );

  logic [NCHG-1:0] chg_set;
  always_comb begin
    chg_set          = '0;
    chg_set[CF_CONN] = conn_edge || en_refused || susp_refused;
    chg_set[CF_EN]   = en_dropped;
    chg_set[CF_SUSP] = resume_fin;
    chg_set[CF_OC]   = oc_edge;
  end

  rh_change_flags #(.N(NCHG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (chg_set),
    .clr_cmd (cmd_chg_clr),
    .flags_q (change_flags)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[POS_CONN]         = dev_connected;
    rd_data[POS_EN]           = port_enable;
    rd_data[POS_SUSP]         = port_suspend;
    rd_data[POS_OC]           = oc_seen;
    rd_data[POS_RSM]          = resume_req;
    rd_data[CHG_TOP:CHG_BASE] = change_flags;
  end

  // R10
  conn_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conn_edge |=> change_flags[CF_CONN]);
  // R5
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_enable && (overcurrent || babble || !port_powered || !dev_connected))
      |=> change_flags[CF_EN]);
  // R4
  sw_clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_en && !en_dropped && !change_flags[CF_EN]) |=> !change_flags[CF_EN]);
  // R8
  resume_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_suspend && resume_req && resume_done) |=> (!port_suspend && change_flags[CF_SUSP]));
  // R3
  refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_set_en || cmd_set_susp) && !dev_connected) |=> change_flags[CF_CONN]);
endmodule

// File: tb/rh_port_reg_tb.sv
`timescale 1ns/1ps
module rh_port_reg_tb;
  localparam int DW = 32;
  localparam bit OCP = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic dev_connected = 1'b0, port_powered = 1'b1, overcurrent = 1'b0, babble = 1'b0;
  logic reset_done = 1'b0, resume_done = 1'b0, hc_resume = 1'b0;
  logic [DW-1:0] rd_data;
  logic port_enable, port_suspend, resume_req;
  logic [3:0] change_flags;

  always #4 clk = ~clk;  // 125 MHz

  rh_port_reg #(.DATA_W(DW), .OC_PER_PORT(OCP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_connected(dev_connected), .port_powered(port_powered), .overcurrent(overcurrent),
    .babble(babble), .reset_done(reset_done), .resume_done(resume_done), .hc_resume(hc_resume),
    .port_enable(port_enable), .port_suspend(port_suspend), .resume_req(resume_req),
    .change_flags(change_flags)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // behavioural reference model
  bit m_en, m_sus, m_rsm, m_cq, m_oq;
  bit [3:0] m_fl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sus = 0; m_rsm = 0; m_cq = 0; m_oq = 0; m_fl = 0;
    end else begin
      bit off, fin, n_en, n_sus, n_rsm;
      bit [3:0] setv, clrv;
      off = !dev_connected || !port_powered || overcurrent || babble;
      fin = m_sus && m_rsm && resume_done;
      n_en = m_en;
      if (off) n_en = 0;
      else if (wr_en && wr_data[0]) n_en = 0;
      else if ((wr_en && wr_data[1]) || reset_done || fin) n_en = 1;
      n_sus = m_sus;
      if (!dev_connected || reset_done || hc_resume || fin) n_sus = 0;
      else if (wr_en && wr_data[2]) n_sus = 1;
      n_rsm = n_sus && (m_rsm || (wr_en && wr_data[3] && m_sus));
      setv[0] = (dev_connected != m_cq) || (wr_en && !dev_connected && (wr_data[1] || wr_data[2]));
      setv[1] = m_en && off;
      setv[2] = fin;
      setv[3] = OCP && (overcurrent != m_oq);
      clrv = wr_en ? wr_data[19:16] : 4'b0;
      for (int i = 0; i < 4; i++) m_fl[i] = setv[i] || (m_fl[i] && !clrv[i]);
      m_en = n_en; m_sus = n_sus; m_rsm = n_rsm;
      m_cq = dev_connected; m_oq = overcurrent;
    end
  end

  function automatic logic [DW-1:0] model_rd();
    logic [DW-1:0] r = '0;
    r[0] = dev_connected; r[1] = m_en; r[2] = m_sus;
    r[3] = OCP ? overcurrent : 1'b0; r[4] = m_rsm; r[19:16] = m_fl;
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R3/R4/R5/R6 enable", {31'b0, port_enable}, {31'b0, m_en});
      cmp("R7/R9 suspend", {31'b0, port_suspend}, {31'b0, m_sus});
      cmp("R8 resume request", {31'b0, resume_req}, {31'b0, m_rsm});
      cmp("R10/R11/R12 flags", {28'b0, change_flags}, {28'b0, m_fl});
      cmp("R2 read word", rd_data, model_rd());
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    cmp(tag, act, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk("R1 reset enable", {31'b0, port_enable}, 32'd0);
    chk("R1 reset suspend/resume", {30'b0, port_suspend, resume_req}, 32'd0);
    chk("R1 reset flags", {28'b0, change_flags}, 32'd0);

    wr(32'h2);                      // set enable on empty port
    chk("R3 refused enable", {31'b0, port_enable}, 32'd0);
    chk("R3 refused sets connect change", {28'b0, change_flags}, 32'h1);
    wr(32'h1 << 16);
    chk("R12 clear connect change", {28'b0, change_flags}, 32'h0);

    dev_connected = 1'b1; tick();
    chk("R10 attach sets connect change", {28'b0, change_flags}, 32'h1);
    chk("R2 present bit", {31'b0, rd_data[0]}, 32'd1);
    wr(32'h1 << 16);

    wr(32'h2);
    chk("R3 enable set", {31'b0, port_enable}, 32'd1);
    wr(32'h1);
    chk("R4 enable cleared", {31'b0, port_enable}, 32'd0);
    chk("R4 no enable change", {31'b0, change_flags[1]}, 32'd0);

    reset_done = 1'b1; tick(); reset_done = 1'b0;
    chk("R6 reset completion enables", {31'b0, port_enable}, 32'd1);

    wr(32'h8);
    chk("R8 resume ignored when not suspended", {31'b0, resume_req}, 32'd0);
    wr(32'h4);
    chk("R7 suspend set", {31'b0, port_suspend}, 32'd1);
    wr(32'h8);
    chk("R8 resume requested, still suspended", {30'b0, port_suspend, resume_req}, 32'd3);
    resume_done = 1'b1; tick(); resume_done = 1'b0;
    chk("R8 resume finished", {30'b0, port_suspend, resume_req}, 32'd0);
    chk("R8 suspend change set", {28'b0, change_flags}, 32'h4);
    chk("R6 enabled after resume", {31'b0, port_enable}, 32'd1);
    wr(32'h1 << 18);

    overcurrent = 1'b1; tick();
    chk("R5 overcurrent disables", {31'b0, port_enable}, 32'd0);
    chk("R11 overcurrent and R5 enable change", {28'b0, change_flags}, 32'ha);
    chk("R2 overcurrent bit", {31'b0, rd_data[3]}, 32'd1);
    overcurrent = 1'b0;
    wr(32'h1 << 19);                // clear races with falling overcurrent
    chk("R12 hardware set wins", {31'b0, change_flags[3]}, 32'd1);
    wr((32'h1 << 19) | (32'h1 << 17));
    chk("R12 flags cleared", {28'b0, change_flags}, 32'h0);

    wr(32'h2);
    wr(32'h4);
    hc_resume = 1'b1; tick(); hc_resume = 1'b0;
    chk("R9 controller resume clears suspend", {31'b0, port_suspend}, 32'd0);
    wr(32'h4);
    wr(32'h8);
    dev_connected = 1'b0; tick();
    chk("R9 detach clears suspend and request", {30'b0, port_suspend, resume_req}, 32'd0);
    chk("R5 R10 detach flags", {28'b0, change_flags}, 32'h3);
    wr(32'hF << 16);
    wr(32'h4);
    chk("R7 refused suspend", {31'b0, port_suspend}, 32'd0);
    chk("R7 refused sets connect change", {28'b0, change_flags}, 32'h1);

    dev_connected = 1'b1; tick();
    wr(32'hF << 16);
    wr(32'h2);
    babble = 1'b1; tick(); babble = 1'b0;
    chk("R5 babble disables", {30'b0, port_enable, change_flags[1]}, 32'd1);
    wr(32'hF << 16);

    // biased random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(15) == 0) dev_connected = ~dev_connected;
      port_powered = ($urandom_range(31) != 0);
      if ($urandom_range(23) == 0) overcurrent = ~overcurrent;
      babble      = ($urandom_range(31) == 0);
      reset_done  = ($urandom_range(19) == 0);
      resume_done = ($urandom_range(3) == 0);
      hc_resume   = ($urandom_range(39) == 0);
      wr_en       = ($urandom_range(2) == 0);
      wr_data     = {12'b0, 4'($urandom), 12'b0, 4'($urandom)};
      tick();
    end
    wr_en = 1'b0; reset_done = 1'b0; resume_done = 1'b0; hc_resume = 1'b0; babble = 1'b0;
    tick();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule